// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block sits between an 8-bit microcontroller bus and an internal register file of up to 256 bytes. It accepts either bus family through one set of pins: a family with separate active-low read and write strobes, or a family with one active-low data strobe and a read/write direction line. Each family can run with a shared address/data bus, where an address latch enable pulse loads the address, or with a separate address bus. No pin selects between these two address forms. The block switches to shared-bus operation the first time it sees the latch enable go high, and it stays there until reset.

A second strap pin selects the addressing scheme. In direct mode, every host address maps one-to-one onto a register-file location. In indirect mode, only address bit 0 is decoded. Location 0 holds an internal address pointer, and location 1 is a window onto the register that the pointer selects. This lets the block occupy two bus locations in place of 256.

All bus control lines are sampled on the internal clock through a two-flop synchroniser before any edge is detected. The register-file side is a push interface without back-pressure. A write request is a one-cycle `rf_we` pulse, and the register file must accept it in that cycle. A read request is a one-cycle `rf_re` pulse, and `rf_rdata` must hold the addressed byte in the cycle after the pulse.

Top module: `hostbus_regport`

## Requirements
- R1: After reset `rf_we`, `rf_re` and `ad_oe` are low, the pointer is 0 and shared-bus operation is off.
- R2: While `cs_n` is high, strobe activity causes no `rf_we` or `rf_re` pulse and leaves the register contents unchanged.
- R3: With `strap_moto`=0, a write is marked by `dir_wr` (write strobe) low. When that strobe returns high, one `rf_we` pulse carries the address and the data held on `ad_in` during the strobe.
- R4: With `strap_moto`=0, `strb_n` (read strobe) low gives one single-cycle `rf_re` pulse. While the strobe is held, `ad_oe` is high and `ad_out` carries the byte returned on `rf_rdata`. `ad_oe` falls after the strobe is released.
- R5: With `strap_moto`=1, `strb_n` is the data strobe and `dir_wr` is the direction line, where 1 means read and 0 means write. A write is committed only after the data strobe rises, and never while it is still low.
- R6: Shared-bus operation starts at the first `ale` high and remains on until reset. From then on the `addr_in` pins are ignored, and an access with no new `ale` pulse reuses the last latched address.
- R7: In shared-bus operation the address is taken from `ad_in` while `ale` is high.
- R8: With `strap_indirect`=1 only address bit 0 is decoded. A write to location 0 loads the pointer from the data byte and gives no `rf_we` pulse.
- R9: With `strap_indirect`=1, a read of location 0 returns the pointer without an `rf_re` pulse. A read or write of location 1 accesses the register-file address held in the pointer.
- R10: Each bus access gives at most one register-file pulse. `rf_we` and `rf_re` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_indirect | input | 1 | 0 direct addressing, 1 pointer/window addressing (static) |
| strap_moto | input | 1 | 0 dual-strobe family, 1 data-strobe plus direction family (static) |
| cs_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Read strobe (dual-strobe family) or data strobe (other family), active low |
| dir_wr | input | 1 | Write strobe, active low (dual-strobe family) or direction line, 1 means read (other family) |
| ale | input | 1 | Address latch enable, active high |
| addr_in | input | ADDR_W | Separate address bus |
| ad_in | input | DATA_W | Data bus in; also carries the address in shared-bus operation |
| ad_out | output | DATA_W | Read data towards the host |
| ad_oe | output | 1 | High while a read is open, so the host pad may drive `ad_out` |
| rf_addr | output | ADDR_W | Register-file address |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_we | output | 1 | One-cycle write request |
| rf_re | output | 1 | One-cycle read request |
| rf_rdata | input | DATA_W | Register-file read data, valid in the cycle after `rf_re` |

## Verification
A corrupted pointer or latched address shows up as an `rf_we` pulse at the wrong `rf_addr`, about three clocks after the write strobe is released. It also shows up as wrong `ad_out` bytes on the next read, a few clocks into the strobe. A wrong bus-family decode or a stuck shared-bus flag shows up in one of two ways: a register-file pulse appears where none is due, or an expected pulse is missing. Either is visible within the three-cycle edge-detection latency. Every write pulse is matched against an ordered list of expected address/data pairs, so an extra pulse, a missing pulse or a swapped target is reported at the access that caused it.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic {
    BUS_DUAL_STROBE = 1'b0,
    BUS_DATA_STROBE = 1'b1
  } bus_family_e;

  typedef struct packed {
    logic start;     // access opened this cycle
    logic rd_start;  // a read opened this cycle
    logic wr_fin;    // a write closed this cycle
    logic open;      // an access is in progress (registered)
    logic is_read;   // direction of the open access (registered)
  } acc_evt_t;

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  bus_family_e family,
  input  logic        cs_n_s,
  input  logic        strb_n_s,
  input  logic        dir_wr_s,
  output acc_evt_t    evt
);

  logic acc_now, dir_rd_now;
  logic open_q, is_read_q;

  always_comb begin
    if (family == BUS_DATA_STROBE) begin
      acc_now    = !cs_n_s && !strb_n_s;
      dir_rd_now = dir_wr_s;
    end else begin
      acc_now    = !cs_n_s && (!strb_n_s || !dir_wr_s);
      dir_rd_now = !strb_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      is_read_q <= 1'b0;
    end else begin
      open_q <= acc_now;
      if (acc_now && !open_q) is_read_q <= dir_rd_now;
    end
  end

  always_comb begin
    evt.start    = acc_now && !open_q;
    evt.rd_start = acc_now && !open_q && dir_rd_now;
    evt.wr_fin   = !acc_now && open_q && !is_read_q;
    evt.open     = open_q;
    evt.is_read  = is_read_q;
  end

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && acc_now) |=> $stable(is_read_q)) else $error("direction changed mid-access"); // R5

endmodule

// File: rtl/hbi_addr.sv
module hbi_addr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  output logic              mux_seen,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] alat_q, ptr_q;
  logic              mux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q  <= 1'b0;
      alat_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (ale_s) begin
        mux_q  <= 1'b1;
        alat_q <= ad_in[ADDR_W-1:0];
      end
      if (ptr_load) ptr_q <= ptr_val;
    end
  end

  assign mux_seen = mux_q;
  assign eff_addr = mux_q ? alat_q : addr_in;
  assign ptr      = ptr_q;

  AST_MUX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mux_q |=> mux_q) else $error("shared-bus flag dropped"); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_load |=> $stable(ptr_q)) else $error("pointer moved without load"); // R8

endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_indirect,
  input  logic              strap_moto,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              dir_wr,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [DATA_W-1:0] rf_rdata
);

  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0111; // ale low, strobes/cs high

  logic [CTRL_W-1:0] ctrl_s;
  logic              cs_n_s, strb_n_s, dir_wr_s, ale_s;
  bus_family_e       family;
  acc_evt_t          evt;

  logic              mux_seen, ptr_load;
  logic [ADDR_W-1:0] eff_addr, ptr, acc_addr_q, tgt_now, tgt_fin;
  logic [DATA_W-1:0] wdata_q, rd_q, rf_wdata_q;
  logic [ADDR_W-1:0] rf_addr_q;
  logic              rf_we_q, rf_re_q;
  logic              loc0_now, loc0_fin;

  assign family = bus_family_e'(strap_moto);

  hbi_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ale, dir_wr, strb_n, cs_n}),
    .dout (ctrl_s)
  );
  assign {ale_s, dir_wr_s, strb_n_s, cs_n_s} = ctrl_s;

  hbi_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .family  (family),
    .cs_n_s  (cs_n_s),
    .strb_n_s(strb_n_s),
    .dir_wr_s(dir_wr_s),
    .evt     (evt)
  );

  assign loc0_now = strap_indirect && !eff_addr[0];
  assign loc0_fin = strap_indirect && !acc_addr_q[0];
  assign tgt_now  = strap_indirect ? ptr : eff_addr;
  assign tgt_fin  = strap_indirect ? ptr : acc_addr_q;
  assign ptr_load = evt.wr_fin && loc0_fin;

  hbi_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_s   (ale_s),
    .ad_in   (ad_in),
    .addr_in (addr_in),
    .ptr_load(ptr_load),
    .ptr_val (wdata_q[ADDR_W-1:0]),
    .mux_seen(mux_seen),
    .eff_addr(eff_addr),
    .ptr     (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr_q <= '0;
      wdata_q    <= '0;
      rd_q       <= '0;
      rf_addr_q  <= '0;
      rf_wdata_q <= '0;
      rf_we_q    <= 1'b0;
      rf_re_q    <= 1'b0;
    end else begin
      rf_we_q <= 1'b0;
      rf_re_q <= 1'b0;
      if (evt.start) acc_addr_q <= eff_addr;
      if (evt.open && !evt.is_read) wdata_q <= ad_in;
      if (evt.rd_start) begin
        if (loc0_now) begin
          rd_q <= DATA_W'(ptr);
        end else begin
          rf_re_q   <= 1'b1;
          rf_addr_q <= tgt_now;
        end
      end
      if (rf_re_q) rd_q <= rf_rdata;
      if (evt.wr_fin && !loc0_fin) begin
        rf_we_q    <= 1'b1;
        rf_addr_q  <= tgt_fin;
        rf_wdata_q <= wdata_q;
      end
    end
  end

  assign ad_out   = rd_q;
  assign ad_oe    = evt.open && evt.is_read;
  assign rf_addr  = rf_addr_q;
  assign rf_wdata = rf_wdata_q;
  assign rf_we    = rf_we_q;
  assign rf_re    = rf_re_q;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we) else $error("write pulse too long"); // R10
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re) else $error("read pulse too long"); // R4
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re)) else $error("read and write together"); // R10
  AST_OE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !rf_we) else $error("write during open read"); // R4
  AST_LOC0_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> !rf_we) else $error("pointer write reached register file"); // R8
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !evt.start) else $error("access without select"); // R2

endmodule

// File: tb/hostbus_regport_tb.sv
module hostbus_regport_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_indirect, strap_moto;
  logic       cs_n, strb_n, dir_wr, ale;
  logic [7:0] addr_in, ad_in, ad_out, rf_addr, rf_wdata, rf_rdata;
  logic       ad_oe, rf_we, rf_re;

  int n_cmp = 0, n_bad = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0, muxed = 0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [15:0] sb_q [$];

  always #4 clk = ~clk;

  hostbus_regport dut_i (
    .clk(clk), .rst_n(rst_n), .strap_indirect(strap_indirect), .strap_moto(strap_moto),
    .cs_n(cs_n), .strb_n(strb_n), .dir_wr(dir_wr), .ale(ale), .addr_in(addr_in),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  // bench-side register file
  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected writes as they appear
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      logic [15:0] e;
      we_cnt++;
      if (sb_q.size() == 0) begin
        check(0, "R2/R8 unexpected rf_we", {rf_addr, rf_wdata}, 0);
      end else begin
        e = sb_q.pop_front();
        check({rf_addr, rf_wdata} == e, "R3/R5 write addr/data", {rf_addr, rf_wdata}, e);
      end
    end
    if (rst_n && rf_re) re_cnt++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit ind, input bit moto);
    @(negedge clk);
    rst_n = 0; strap_indirect = ind; strap_moto = moto;
    cs_n = 1; strb_n = 1; dir_wr = moto ? 1'b1 : 1'b1; ale = 0;
    addr_in = 8'h00; ad_in = 8'h00; muxed = 0;
    idle(3);
    rst_n = 1;
    idle(3);
  endtask

  task automatic addr_phase(input logic [7:0] a, input bit use_ale);
    if (use_ale) begin
      ale = 1; ad_in = a; idle(4);
      ale = 0; idle(4);
      muxed = 1;
    end else if (!muxed) begin
      addr_in = a; idle(2);
    end
  endtask

  // write: a = bus address, d = data; want_we/tgt describe the expected pulse
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit use_ale,
                           input bit sel, input bit want_we, input logic [7:0] tgt,
                           input string tag);
    int w0;
    addr_phase(a, use_ale);
    w0 = we_cnt;
    if (want_we) begin
      sb_q.push_back({tgt, d});
      expm[tgt] = d;
    end
    cs_n = !sel; ad_in = d;
    if (strap_moto) begin dir_wr = 0; strb_n = 0; end
    else dir_wr = 0;
    idle(6);
    check(we_cnt == w0, {tag, " R5 no commit while strobe active"}, we_cnt - w0, 0);
    if (strap_moto) strb_n = 1; else dir_wr = 1;
    idle(4);
    cs_n = 1; dir_wr = 1;
    idle(4);
    check(we_cnt - w0 == int'(want_we), {tag, " R10 pulse count"}, we_cnt - w0, int'(want_we));
  endtask

  task automatic bus_read(input logic [7:0] a, input bit use_ale, input bit sel,
                          input logic [7:0] exp, input bit want_re, input string tag);
    int r0;
    addr_phase(a, use_ale);
    r0 = re_cnt;
    cs_n = !sel;
    if (strap_moto) begin dir_wr = 1; strb_n = 0; end
    else strb_n = 0;
    idle(8);
    if (sel) begin
      check(ad_oe == 1'b1, {tag, " R4 ad_oe during read"}, ad_oe, 1);
      check(ad_out == exp, {tag, " read data"}, ad_out, exp);
    end else begin
      check(ad_oe == 1'b0, {tag, " R2 no ad_oe when deselected"}, ad_oe, 0);
    end
    strb_n = 1;
    idle(4);
    cs_n = 1;
    check(ad_oe == 1'b0, {tag, " R4 ad_oe released"}, ad_oe, 0);
    check(re_cnt - r0 == int'(want_re), {tag, " R10 rf_re count"}, re_cnt - r0, int'(want_re));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; expm[i] = 8'h00; end
    rst_n = 0;
    do_reset(0, 0);
    // R1 reset state
    check(rf_we == 0, "R1 rf_we after reset", rf_we, 0);
    check(rf_re == 0, "R1 rf_re after reset", rf_re, 0);
    check(ad_oe == 0, "R1 ad_oe after reset", ad_oe, 0);

    // R3/R4 dual-strobe, separate address bus, direct
    bus_write(8'h12, 8'hA5, 0, 1, 1, 8'h12, "R3 w12");
    bus_write(8'hFF, 8'h3C, 0, 1, 1, 8'hFF, "R3 wFF");
    bus_write(8'h00, 8'h01, 0, 1, 1, 8'h00, "R3 w00");
    bus_read(8'h12, 0, 1, 8'hA5, 1, "R4 r12");
    bus_read(8'hFF, 0, 1, 8'h3C, 1, "R4 rFF");
    bus_read(8'h00, 0, 1, 8'h01, 1, "R4 r00");

    // R2 deselected accesses are ignored
    bus_write(8'h12, 8'h77, 0, 0, 0, 8'h12, "R2 w deselected");
    bus_read(8'h12, 0, 0, 8'h00, 0, "R2 r deselected");
    bus_read(8'h12, 0, 1, 8'hA5, 1, "R2 readback");

    // R5 data-strobe family, direct
    do_reset(0, 1);
    check(ad_oe == 0, "R1 ad_oe after second reset", ad_oe, 0);
    bus_write(8'h40, 8'h5A, 0, 1, 1, 8'h40, "R5 w40");
    bus_read(8'h40, 0, 1, 8'h5A, 1, "R5 r40");
    bus_read(8'hFF, 0, 1, 8'h3C, 1, "R5 rFF");

    // R6/R7 shared bus, dual strobe
    do_reset(0, 0);
    addr_in = 8'h99;
    bus_write(8'h21, 8'hC3, 1, 1, 1, 8'h21, "R7 w21");
    bus_read(8'h21, 1, 1, 8'hC3, 1, "R7 r21");
    addr_in = 8'h55;
    bus_write(8'h00, 8'hD4, 0, 1, 1, 8'h21, "R6 reuse latched");
    bus_read(8'h99, 1, 1, expm[8'h99], 1, "R6 pins ignored");
    bus_read(8'h21, 1, 1, 8'hD4, 1, "R6 r21");

    // R8/R9 indirect, dual strobe, separate bus
    do_reset(1, 0);
    bus_read(8'hFE, 0, 1, 8'h00, 0, "R1 pointer reset");
    bus_write(8'hFE, 8'h12, 0, 1, 0, 8'h00, "R8 ptr load");
    bus_read(8'h02, 0, 1, 8'h12, 0, "R9 ptr readback");
    bus_read(8'h03, 0, 1, 8'hA5, 1, "R9 window read");
    bus_write(8'hE7, 8'h6E, 0, 1, 1, 8'h12, "R9 window write");
    bus_read(8'h01, 0, 1, 8'h6E, 1, "R9 window reread");

    // R8/R9 indirect, data-strobe family, shared bus
    do_reset(1, 1);
    bus_write(8'h00, 8'h40, 1, 1, 0, 8'h00, "R8 ptr load shared");
    bus_read(8'h01, 1, 1, 8'h5A, 1, "R9 window shared");
    bus_read(8'h80, 1, 1, 8'h40, 0, "R9 ptr read shared");

    idle(5);
    check(sb_q.size() == 0, "R10 all expected writes seen", sb_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule